// File: doc/BRIEF.md
# Rate-Adjustable Adder-Based Time Clock

This block keeps the time of day for a network node. It does not count oscillator periods one at a time. On every oscillator tick it adds a programmable increment to a wide time accumulator. The increment is held in nanoseconds plus a 32-bit binary fraction of a nanosecond, so the oscillator can run at any frequency, and the rate can be trimmed in steps far below one nanosecond per second. The time value is 96 bits wide: 32 bits of seconds, 32 bits of nanoseconds that wrap at one billion, and 32 bits of sub-nanosecond fraction.

Offset corrections are never applied as a jump. Instead, a per-tick correction step is added to or taken from the base increment for a programmed number of ticks, so the offset is amortized linearly. The total offset equals the step times the tick count. A leap second can be scheduled so that the next seconds rollover either repeats the current second or skips the next one. A snapshot strobe copies the current time into a 96-bit timestamp register on the edge where it is seen.

Software controls the block through a small write-only register port with one word per cycle. Reads come from the two time outputs.

Top module: `adder_clock`

## Requirements
- R1: A synchronous active-low reset clears the time and the snapshot to zero, sets the base increment to 10 ns per tick, and clears any amortization and any leap request.
- R2: On a cycle with `tick` high, the nanosecond+fraction part (bits 63:0 of `now_time`) grows by the effective increment. With `tick` low, `now_time` holds its value.
- R3: The nanosecond field (bits 63:32) stays below 1,000,000,000. A sum that reaches this value has it subtracted and carries into the seconds field (bits 95:64).
- R4: A write to address 0 only stages the fraction part of a new rate. A write to address 1 sets the base increment to {data, staged fraction}, and the new rate is used from the next cycle onward. A tick in the same cycle as the write still uses the old rate.
- R5: A write to address 2 stages an unsigned correction step in units of 2^-32 ns. A write to address 3 (bit 31 = 1 for subtract, bits 30:0 = tick count) starts an amortization. For the next count ticks the increment is the base plus or minus the step, and after that it is the base again.
- R6: An accepted write to address 3 replaces an amortization still in progress. A count of zero cancels it.
- R7: A subtracting request whose staged step is not below the base increment is ignored. A rate write that would leave a running subtracting step not below the new base cancels that amortization.
- R8: A write to address 4 with bits 1:0 = 1 schedules a leap insert: at the next seconds rollover the seconds field does not advance. With bits 1:0 = 2 it schedules a delete: the seconds field advances by two. A value of 0 cancels the request, and 3 leaves it unchanged. A request is used once.
- R9: When `snap` is high on a clock edge, `snap_time` takes the value `now_time` had before that edge. Otherwise `snap_time` holds.
- R10: `now_time` never decreases on a tick, except at a rollover that carries out a leap insert.
- R11: Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oscillator tick enable, one time step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| snap | input | 1 | Timestamp capture strobe |
| now_time | output | 96 | Current time {seconds, nanoseconds, fraction} |
| snap_time | output | 96 | Last captured timestamp |

## Verification
The assertions assume three things about the inputs. First, the nanosecond part written as the rate is below one billion. Second, the base rate is never zero. Third, an added step does not push the increment past a second; otherwise the nanosecond range and the monotonic property cannot hold. The random stimulus meets these conditions. It draws rate nanoseconds between 1 and 500 million, and tick counts below 20 with 32-bit steps, so every step stays under the smallest allowed base. The only deliberately small rates appear in a directed phase that drives the subtract-rejection and the cancel-on-rate-change paths.

// File: rtl/adder_clock.sv
module adder_clock #(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 32,
  parameter int FRAC_W = 32,
  parameter int STEP_W = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter longint unsigned NS_PER_SEC = 64'd1000000000,
  parameter logic [NS_W+FRAC_W-1:0] RESET_INC = {NS_W'(10), FRAC_W'(0)},
  localparam int TIME_W = SEC_W + NS_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              snap,
  output logic [TIME_W-1:0] now_time,
  output logic [TIME_W-1:0] snap_time
);
  localparam int FINE_W = NS_W + FRAC_W;
  localparam int CNT_W  = DATA_W - 1;
  localparam logic [FINE_W:0] WRAP_FINE = {1'b0, NS_W'(NS_PER_SEC), FRAC_W'(0)};
  localparam logic [ADDR_W-1:0] A_RATE_FRAC = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RATE_NS   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STEP      = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_AMORT     = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_LEAP      = ADDR_W'(4);
  localparam logic [1:0] LEAP_NONE = 2'd0;
  localparam logic [1:0] LEAP_INS  = 2'd1;
  localparam logic [1:0] LEAP_DEL  = 2'd2;

  logic [SEC_W-1:0]  sec_q;
  logic [FINE_W-1:0] fine_q;
  logic [FINE_W-1:0] base_q;
  logic [FRAC_W-1:0] frac_stage_q;
  logic [STEP_W-1:0] step_stage_q;
  logic [STEP_W-1:0] step_q;
  logic              neg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        leap_q;
  logic [TIME_W-1:0] snap_q;

  wire               amo_on   = cnt_q != '0;
  wire  [FINE_W-1:0] step_ext = FINE_W'(step_q);
  wire  [FINE_W-1:0] eff_inc  = !amo_on ? base_q :
                                neg_q   ? base_q - step_ext : base_q + step_ext;
  wire  [FINE_W:0]   sum      = {1'b0, fine_q} + {1'b0, eff_inc};
  wire               wrap     = sum >= WRAP_FINE;
  wire  [FINE_W:0]   sum_wrap = sum - WRAP_FINE;
  wire  [FINE_W-1:0] fine_nx  = wrap ? sum_wrap[FINE_W-1:0] : sum[FINE_W-1:0];

  logic [SEC_W-1:0] sec_nx;
  always_comb begin
    sec_nx = sec_q;
    if (wrap) begin
      case (leap_q)
        LEAP_INS: sec_nx = sec_q;
        LEAP_DEL: sec_nx = sec_q + SEC_W'(2);
        default:  sec_nx = sec_q + SEC_W'(1);
      endcase
    end
  end

  wire              wr_rate  = wr_en && wr_addr == A_RATE_NS;
  wire              wr_amo   = wr_en && wr_addr == A_AMORT;
  wire [FINE_W-1:0] new_base = {NS_W'(wr_data), frac_stage_q};
  wire              req_neg  = wr_data[DATA_W-1];
  wire [CNT_W-1:0]  req_cnt  = CNT_W'(wr_data[DATA_W-2:0]);
  wire              req_ok   = !req_neg || (FINE_W'(step_stage_q) < base_q);
  wire              kill     = wr_rate && amo_on && neg_q && (new_base <= step_ext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q        <= '0;
      fine_q       <= '0;
      base_q       <= RESET_INC;
      frac_stage_q <= '0;
      step_stage_q <= '0;
      step_q       <= '0;
      neg_q        <= 1'b0;
      cnt_q        <= '0;
      leap_q       <= LEAP_NONE;
      snap_q       <= '0;
    end else begin
      if (tick) begin
        sec_q  <= sec_nx;
        fine_q <= fine_nx;
        if (wrap) leap_q <= LEAP_NONE;
      end
      if (snap) snap_q <= {sec_q, fine_q};

      if (wr_amo && req_ok) begin
        cnt_q  <= req_cnt;
        neg_q  <= req_neg;
        step_q <= step_stage_q;
      end else if (kill) begin
        cnt_q <= '0;
      end else if (tick && amo_on) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end

      if (wr_en) begin
        case (wr_addr)
          A_RATE_FRAC: frac_stage_q <= FRAC_W'(wr_data);
          A_RATE_NS:   base_q       <= new_base;
          A_STEP:      step_stage_q <= STEP_W'(wr_data);
          A_LEAP:      if (wr_data[1:0] != 2'd3) leap_q <= wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  assign now_time  = {sec_q, fine_q};
  assign snap_time = snap_q;
endmodule

// File: rtl/adder_clock_chk.sv
module adder_clock_chk #(
  parameter int TIME_W = 96,
  parameter int FRAC_W = 32,
  parameter int NS_W   = 32,
  parameter longint unsigned NS_PER_SEC = 64'd1000000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              snap,
  input logic              leap_ins,
  input logic [TIME_W-1:0] now_time,
  input logic [TIME_W-1:0] snap_time
);
  wire [NS_W-1:0] ns_field = now_time[FRAC_W +: NS_W];

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (now_time == '0 && snap_time == '0));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(now_time));

  a_r3_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
    ns_field < NS_W'(NS_PER_SEC));

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> snap_time == $past(now_time));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(snap_time));

  a_r10_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !leap_ins) |=> now_time >= $past(now_time));
endmodule

bind adder_clock adder_clock_chk #(
  .TIME_W(TIME_W), .FRAC_W(FRAC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .snap(snap),
  .leap_ins(leap_q == 2'd1), .now_time(now_time), .snap_time(snap_time)
);

// File: tb/sim_adder_clock.sv
module sim_adder_clock;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;
  localparam logic [63:0] WRAP64 = {32'd1000000000, 32'd0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, snap = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [95:0] now_time, snap_time;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  logic [31:0] m_sec;
  logic [63:0] m_fine, m_base;
  logic [31:0] m_sfrac, m_sstep, m_step;
  bit          m_neg;
  logic [30:0] m_cnt;
  logic [1:0]  m_leap;
  logic [95:0] m_snap;

  adder_clock u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .snap(snap), .now_time(now_time), .snap_time(snap_time)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ns_of(input logic [95:0] t);
    return t[63:32];
  endfunction

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sec = '0; m_fine = '0; m_base = {32'd10, 32'd0};
    m_sfrac = '0; m_sstep = '0; m_step = '0; m_neg = 0; m_cnt = '0;
    m_leap = '0; m_snap = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 0; wr_en = 0; snap = 0;
    @(posedge clk);
    @(posedge clk);
    #1;
    model_reset();
    check("R1 time after reset", now_time, 96'd0);
    check("R1 snapshot after reset", snap_time, 96'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cyc(input bit t, input bit w, input logic [2:0] a,
                     input logic [31:0] d, input bit s, input string tag);
    logic [31:0] n_sec, n_sfrac, n_sstep, n_step;
    logic [63:0] n_fine, n_base, eff, stepx, nb;
    logic [64:0] sum;
    bit          n_neg, on, wrap;
    logic [30:0] n_cnt;
    logic [1:0]  n_leap;
    logic [95:0] n_snap;
    @(negedge clk);
    tick = t; wr_en = w; wr_addr = a; wr_data = d; snap = s;
    n_sec = m_sec; n_fine = m_fine; n_base = m_base; n_sfrac = m_sfrac;
    n_sstep = m_sstep; n_step = m_step; n_neg = m_neg; n_cnt = m_cnt;
    n_leap = m_leap; n_snap = m_snap;
    on = m_cnt != 0;
    stepx = {32'd0, m_step};
    if (t) begin
      eff = !on ? m_base : (m_neg ? m_base - stepx : m_base + stepx);
      sum = {1'b0, m_fine} + {1'b0, eff};
      wrap = sum >= {1'b0, WRAP64};
      if (wrap) begin
        sum = sum - {1'b0, WRAP64};
        n_sec = (m_leap == 2'd1) ? m_sec : (m_leap == 2'd2) ? m_sec + 32'd2 : m_sec + 32'd1;
        n_leap = 2'd0;
      end
      n_fine = sum[63:0];
      if (on) n_cnt = m_cnt - 31'd1;
    end
    if (s) n_snap = {m_sec, m_fine};
    if (w) begin
      case (a)
        3'd0: n_sfrac = d;
        3'd1: begin
          nb = {d, m_sfrac};
          n_base = nb;
          if (on && m_neg && nb <= stepx) n_cnt = '0;
        end
        3'd2: n_sstep = d;
        3'd3: if (!d[31] || {32'd0, m_sstep} < m_base) begin
          n_cnt = d[30:0]; n_neg = d[31]; n_step = m_sstep;
        end
        3'd4: if (d[1:0] != 2'd3) n_leap = d[1:0];
        default: ;
      endcase
    end
    @(posedge clk);
    m_sec = n_sec; m_fine = n_fine; m_base = n_base; m_sfrac = n_sfrac;
    m_sstep = n_sstep; m_step = n_step; m_neg = n_neg; m_cnt = n_cnt;
    m_leap = n_leap; m_snap = n_snap;
    #1;
    check({tag, " time"}, now_time, {m_sec, m_fine});
    check({tag, " snapshot"}, snap_time, m_snap);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    cyc(0, 1, a, d, 0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 3'd0, 32'd0, 0, tag);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > MAX_CYCLES && !done) begin
        fails++; checks++;
        $display("FAIL all: watchdog expired, actual %0d cycles expected below %0d", cycles, MAX_CYCLES);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [95:0] prev, pre;
    logic [31:0] d;
    logic [2:0]  a;
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    // R1: default rate of 10 ns
    ticks(1, "R1");
    check("R1 default increment", now_time, {32'd0, 32'd10, 32'd0});

    // R11: unused addresses
    wr(3'd5, 32'hFFFF_FFFF, "R11");
    wr(3'd6, 32'h1234_5678, "R11");
    wr(3'd7, 32'h8000_0005, "R11");
    ticks(1, "R11");
    check("R11 rate unchanged", now_time, {32'd0, 32'd20, 32'd0});

    // R4: staging and commit timing
    wr(3'd0, 32'h8000_0000, "R4");
    ticks(1, "R4");
    check("R4 staged fraction unused", now_time, {32'd0, 32'd30, 32'd0});
    cyc(1, 1, 3'd1, 32'd7, 0, "R4");
    check("R4 old rate on write cycle", now_time, {32'd0, 32'd40, 32'd0});
    ticks(1, "R4");
    check("R4 new rate", now_time, {32'd0, 32'd47, 32'h8000_0000});

    // R2: idle and ticking mix
    for (int i = 0; i < 40; i++) cyc(($urandom % 2) == 1, 0, 3'd0, 32'd0, 0, "R2");

    // R9: snapshot with simultaneous tick
    pre = now_time;
    cyc(1, 0, 3'd0, 32'd0, 1, "R9");
    check("R9 capture pre-edge value", snap_time, pre);
    for (int i = 0; i < 30; i++) cyc(($urandom % 2) == 1, 0, 3'd0, 32'd0, ($urandom % 3) == 0, "R9");

    // R3: rollover with 250 ms rate
    wr(3'd0, 32'd0, "R3");
    wr(3'd1, 32'd250000000, "R3");
    ticks(41, "R3");

    // R5: amortization add
    wr(3'd1, 32'd100, "R5");
    wr(3'd2, 32'h4000_0000, "R5");
    wr(3'd3, 32'd2, "R5");
    for (int i = 0; i < 3; i++) begin
      prev = now_time;
      ticks(1, "R5");
      check("R5 per-tick delta", {32'd0, now_time[63:0] - prev[63:0]},
            {32'd0, 32'd100, (i < 2) ? 32'h4000_0000 : 32'd0});
    end
    wr(3'd3, 32'h8000_0004, "R5");
    ticks(6, "R5");

    // R6: replace and cancel
    wr(3'd3, 32'h8000_0064, "R6");
    ticks(3, "R6");
    wr(3'd3, 32'd2, "R6");
    ticks(4, "R6");
    wr(3'd3, 32'd50, "R6");
    ticks(2, "R6");
    wr(3'd3, 32'd0, "R6");
    prev = now_time;
    ticks(1, "R6");
    check("R6 cancelled delta", {32'd0, now_time[63:0] - prev[63:0]}, {32'd0, 32'd100, 32'd0});

    // R7: reject oversize subtract, cancel on rate change
    wr(3'd0, 32'h1000, "R7");
    wr(3'd1, 32'd0, "R7");
    wr(3'd2, 32'h2000, "R7");
    wr(3'd3, 32'h8000_000A, "R7");
    prev = now_time;
    ticks(1, "R7");
    check("R7 rejected request", {32'd0, now_time[63:0] - prev[63:0]}, {64'd0, 32'h1000});
    wr(3'd0, 32'h10000, "R7");
    wr(3'd1, 32'd0, "R7");
    wr(3'd2, 32'h8000, "R7");
    wr(3'd3, 32'h8000_0032, "R7");
    ticks(3, "R7");
    wr(3'd0, 32'h4000, "R7");
    wr(3'd1, 32'd0, "R7");
    prev = now_time;
    ticks(1, "R7");
    check("R7 cancel on rate write", {32'd0, now_time[63:0] - prev[63:0]}, {64'd0, 32'h4000});
    ticks(5, "R7");

    // R8: leap insert, normal, delete, cancel, no-op code
    wr(3'd0, 32'd0, "R8");
    wr(3'd1, 32'd250000000, "R8");
    wr(3'd4, 32'd1, "R8");
    wr(3'd4, 32'd3, "R8");
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 8; i++) begin
        prev = now_time;
        ticks(1, "R8");
        if (ns_of(now_time) < ns_of(prev)) begin
          check("R8 seconds at rollover", {64'd0, now_time[95:64]},
                {64'd0, prev[95:64] + ((k == 0) ? 32'd0 : (k == 1) ? 32'd1 : 32'd2)});
          break;
        end
      end
      if (k == 0) ticks(1, "R8");
      if (k == 1) wr(3'd4, 32'd2, "R8");
    end
    wr(3'd4, 32'd2, "R8");
    wr(3'd4, 32'd0, "R8");
    ticks(8, "R8");

    // R10: constrained random mix
    for (int i = 0; i < 4000; i++) begin
      a = 3'($urandom % 8);
      case (a)
        3'd1: d = 32'd1 + ($urandom % 500000000);
        3'd3: d = {1'($urandom % 2), 31'($urandom % 20)};
        3'd4: d = $urandom % 4;
        default: d = $urandom;
      endcase
      cyc(($urandom % 4) != 0, ($urandom % 6) == 0, a, d, ($urandom % 8) == 0, "R10");
    end

    // R1: reset in mid-run
    do_reset();
    ticks(2, "R1");
    check("R1 rate after second reset", now_time, {32'd0, 32'd20, 32'd0});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule